// File: doc/BRIEF.md
# Commutation-Gated Output Control Register

This block holds the run-time output control word of each channel that has a complementary output pair. Each word has three fields: a main-output enable, a complementary-output enable, and an output-mode code. Software updates a word through a simple write port. Downstream waveform logic reads the active copy of every word.

The staging input can be off. In that case a written word becomes active on the clock edge that accepts the write. When staging is on, writes collect in a shadow bank. The whole bank is then copied into the active bank at one instant, on a commutation event. This lets several channels change their drive pattern together.

A commutation event always comes from a single-cycle software strobe. A source-select input can also make a rising edge on the trigger input produce one. The trigger input is edge-detected against its value from the previous clock.

Top module: `commut_preload_ctrl`

## Requirements
- R1: Reset (active low, asynchronous) clears the shadow bank, the active bank and the trigger history. So a trigger input that is high in the first cycle after reset counts as a rising edge, and a word written before reset never reaches the active bank.
- R2: With `stage_en` low, a write to channel c appears on `act_ctrl[c*CW +: CW]` after the clock edge that accepts it. Each word is laid out as bit 0 main enable, bit 1 complementary enable, bits CW-1..2 mode, with CW = MODE_W+2.
- R3: With `stage_en` high, a write changes the shadow word only. `act_ctrl` keeps its value until a commutation event occurs.
- R4: A high `sw_com` in a cycle with `stage_en` high copies the whole shadow bank into the active bank at that clock edge.
- R5: With `trg_src_sel` low, edges on `trg_in` never cause a commutation event.
- R6: With `trg_src_sel` high, a cycle where `trg_in` is high and was low in the previous cycle causes a commutation event. A level held high causes no further event.
- R7: When a write and a commutation event fall in the same cycle, the newly written word is the one copied to the active bank.
- R8: When `stage_en` drops from 1 to 0, the active bank takes the shadow contents at the next clock edge, without a commutation event.
- R9: A write alters only the channel selected by `wr_ch`. A write with `wr_ch` ≥ NCH alters no channel.
- R10: A falling edge on `trg_in` never causes a commutation event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one control word |
| wr_ch | input | CHW | Channel index of the write |
| wr_data | input | CW | Control word: bit 0 enable, bit 1 complementary enable, upper bits mode |
| stage_en | input | 1 | 1: writes are staged until commutation; 0: writes apply directly |
| trg_src_sel | input | 1 | 1: trigger rising edges also commutate; 0: software strobe only |
| trg_in | input | 1 | Trigger input |
| sw_com | input | 1 | Single-cycle software commutation strobe |
| act_ctrl | output | NCH*CW | Active control words, channel c at bits c*CW +: CW |

## Verification
Several properties are checked by the assertions on every cycle. The active bank holds while staging is on and no event occurs. A direct or commutating write lands with its new value. Edge strobes last one cycle. Masking of the trigger source and the one-hot write decode are also checked each cycle.

Other behaviours need a sequence of steps, so only the bench scenarios can show them:
- the whole bank transferring together;
- a held trigger level or a falling edge not retriggering;
- the 1-to-0 staging switch releasing shadow contents;
- reset clearing the trigger history and the shadow words.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  // rising edge of a level compared against its registered copy
  function automatic logic f_rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // commutation event from software strobe and optional trigger edge
  function automatic logic f_com(input logic sw, input logic sel, input logic rise);
    return sw | (sel & rise);
  endfunction

  // should the active word load this cycle
  function automatic logic f_load(input logic staged, input logic com);
    return ~staged | com;
  endfunction
endpackage

// File: rtl/cmt_edge.sv
module cmt_edge
  import cmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trg_in,
  output logic trg_rise
);
  logic trg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trg_q <= 1'b0;
    else        trg_q <= trg_in;
  end

  assign trg_rise = f_rise(trg_in, trg_q);

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trg_rise |=> !trg_rise); // R6
endmodule

// File: rtl/cmt_src.sv
module cmt_src
  import cmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_com,
  input  logic trg_src_sel,
  input  logic trg_rise,
  output logic com_evt
);
  assign com_evt = f_com(sw_com, trg_src_sel, trg_rise);

  AST_TRIG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!trg_src_sel && !sw_com) |-> !com_evt); // R5
  AST_SW_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    sw_com |-> com_evt); // R4
endmodule

// File: rtl/cmt_chan.sv
module cmt_chan
  import cmt_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [CW-1:0] wr_data,
  input  logic          stage_en,
  input  logic          com_evt,
  output logic [CW-1:0] act
);
  logic [CW-1:0] shadow_q;
  logic [CW-1:0] shadow_nxt;
  logic          act_load;

  assign shadow_nxt = wr_hit ? wr_data : shadow_q;
  assign act_load   = f_load(stage_en, com_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act      <= '0;
    end else begin
      shadow_q <= shadow_nxt;
      if (act_load) act <= shadow_nxt;
    end
  end

  AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_en && !com_evt) |=> $stable(act)); // R3
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_en && wr_hit) |=> (act == $past(wr_data))); // R2
  AST_COM_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_en && com_evt && wr_hit) |=> (act == $past(wr_data))); // R7
endmodule

// File: rtl/commut_preload_ctrl.sv
module commut_preload_ctrl #(
  parameter int NCH    = 3,
  parameter int MODE_W = 3,
  parameter int CW     = MODE_W + 2,
  parameter int CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CHW-1:0]    wr_ch,
  input  logic [CW-1:0]     wr_data,
  input  logic              stage_en,
  input  logic              trg_src_sel,
  input  logic              trg_in,
  input  logic              sw_com,
  output logic [NCH*CW-1:0] act_ctrl
);
  logic           trg_rise;
  logic           com_evt;
  logic [NCH-1:0] wr_hit;

  cmt_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .trg_in   (trg_in),
    .trg_rise (trg_rise)
  );

  cmt_src u_src (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_com      (sw_com),
    .trg_src_sel (trg_src_sel),
    .trg_rise    (trg_rise),
    .com_evt     (com_evt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign wr_hit[c] = wr_en && (wr_ch == CHW'(c));

    cmt_chan #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_hit[c]),
      .wr_data  (wr_data),
      .stage_en (stage_en),
      .com_evt  (com_evt),
      .act      (act_ctrl[c*CW +: CW])
    );
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit)); // R9
  AST_WR_OOR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_ch) >= NCH)) |-> (wr_hit == '0)); // R9
endmodule

// File: tb/tb_commut_preload_ctrl.sv
module tb_commut_preload_ctrl;
  localparam int NCH = 3;
  localparam int CW  = 5;
  localparam int TW  = NCH * CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_ch;
  logic [CW-1:0] wr_data;
  logic          stage_en, trg_src_sel, trg_in, sw_com;
  logic [TW-1:0] act_ctrl;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  commut_preload_ctrl #(.NCH(NCH), .MODE_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .stage_en(stage_en), .trg_src_sel(trg_src_sel), .trg_in(trg_in),
    .sw_com(sw_com), .act_ctrl(act_ctrl)
  );

  // {we, ch, data, stage, sel, trg, sw, expected {ch2,ch1,ch0}}
  localparam int NV = 15;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1,2'd0,5'h05, 1'b0,1'b0,1'b0,1'b0, 5'h00,5'h00,5'h05}, // R2 direct ch0
    {1'b1,2'd1,5'h1A, 1'b0,1'b0,1'b0,1'b0, 5'h00,5'h1A,5'h05}, // R2 direct ch1
    {1'b1,2'd2,5'h13, 1'b1,1'b0,1'b0,1'b0, 5'h00,5'h1A,5'h05}, // R3 staged ch2
    {1'b1,2'd0,5'h0E, 1'b1,1'b0,1'b0,1'b0, 5'h00,5'h1A,5'h05}, // R3 staged ch0
    {1'b0,2'd0,5'h00, 1'b1,1'b0,1'b1,1'b0, 5'h00,5'h1A,5'h05}, // R5 edge masked
    {1'b0,2'd0,5'h00, 1'b1,1'b0,1'b0,1'b0, 5'h00,5'h1A,5'h05}, // R5 idle
    {1'b0,2'd0,5'h00, 1'b1,1'b0,1'b0,1'b1, 5'h13,5'h1A,5'h0E}, // R4 sw commutation
    {1'b1,2'd1,5'h07, 1'b1,1'b1,1'b1,1'b0, 5'h13,5'h07,5'h0E}, // R6 R7 edge + write
    {1'b1,2'd2,5'h1F, 1'b1,1'b1,1'b1,1'b0, 5'h13,5'h07,5'h0E}, // R6 held level
    {1'b0,2'd0,5'h00, 1'b1,1'b1,1'b0,1'b0, 5'h13,5'h07,5'h0E}, // R10 falling edge
    {1'b0,2'd0,5'h00, 1'b1,1'b1,1'b1,1'b0, 5'h1F,5'h07,5'h0E}, // R6 new rise
    {1'b1,2'd3,5'h1C, 1'b1,1'b0,1'b0,1'b1, 5'h1F,5'h07,5'h0E}, // R9 out of range
    {1'b1,2'd0,5'h11, 1'b1,1'b0,1'b0,1'b0, 5'h1F,5'h07,5'h0E}, // R3 staged ch0
    {1'b0,2'd0,5'h00, 1'b0,1'b0,1'b0,1'b0, 5'h1F,5'h07,5'h11}, // R8 stage off
    {1'b1,2'd2,5'h00, 1'b0,1'b0,1'b0,1'b0, 5'h00,5'h07,5'h11}  // R2 R9 direct ch2
  };
  localparam string VREQ [NV] = '{"R2","R2","R3","R3","R5","R5","R4","R7",
                                  "R6","R10","R6","R9","R3","R8","R9"};

  task automatic drive(input logic [26:0] v);
    wr_en       = v[26];
    wr_ch       = v[25:24];
    wr_data     = v[23:19];
    stage_en    = v[18];
    trg_src_sel = v[17];
    trg_in      = v[16];
    sw_com      = v[15];
  endtask

  task automatic check(input string req, input logic [TW-1:0] exp);
    checks++;
    if (act_ctrl !== exp) begin
      fails++;
      $display("FAIL %s act_ctrl=%h expected=%h", req, act_ctrl, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    check("R1", '0); // reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check(VREQ[i], VEC[i][14:0]);
    end

    // stage a word on ch1, then reset: it must never become active (R1)
    drive({1'b1,2'd1,5'h0A, 1'b1,1'b0,1'b0,1'b0, 15'h0});
    @(negedge clk);
    check("R3", {5'h00,5'h07,5'h11});
    rst_n = 1'b0;
    drive({1'b0,2'd0,5'h00, 1'b0,1'b1,1'b1,1'b0, 15'h0}); // trigger high during reset
    @(negedge clk);
    check("R1", '0);
    rst_n = 1'b1;
    // trigger still high: history was cleared, so this is a rising edge (R1)
    drive({1'b1,2'd0,5'h03, 1'b1,1'b1,1'b1,1'b0, 15'h0});
    @(negedge clk);
    check("R1", {5'h00,5'h00,5'h03});
    // staging off: ch1 shadow was cleared by reset (R1)
    drive({1'b0,2'd0,5'h00, 1'b0,1'b0,1'b1,1'b0, 15'h0});
    @(negedge clk);
    check("R1", {5'h00,5'h00,5'h03});

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule